// File: doc/BRIEF.md
# Page Storage-Key Reference/Change Updater

This block keeps one key byte per 4 KB page of absolute storage and refreshes it whenever a translation finishes. Every accepted request names an absolute address, an access kind (read, write or fetch) and the write permission that the earlier translation stages granted. The block reads the page's key byte, marks it referenced, marks it changed on a write, and writes it back. It returns the updated key together with an adjusted write permission.

On a read, the returned write permission is withdrawn while the page's change bit is still clear. A later store to that page therefore cannot reuse the permission silently. It has to come back through the updater as a write, and the write sets the change bit.

Addresses at or above a supplied memory-size limit bypass the key memory. For those requests the permission flag passes through untouched. Each update takes two busy cycles after acceptance, and a ready signal holds off further requests until the update is done.

Top module: `pgkey_track`

## Requirements
- R1: After reset `req_ready` is 1. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 for exactly two cycles and returns to 1 in the third cycle after acceptance.
- R2: `rsp_valid` is 1 for exactly one cycle, in the third cycle after acceptance, which is the same cycle in which `req_ready` returns to 1.
- R3: The key entry is selected by the absolute address shifted right by 12. Addresses with different low 12 bits on the same page share one key.
- R4: A request with `req_addr >= mem_limit` leaves every key unchanged. It returns `rsp_skip`=1, `rsp_key`=0 and `rsp_wr_ok` equal to `req_wr_ok`. An address of `mem_limit - 1` is updated normally.
- R5: Access kind code 0 is a read. For a read, `rsp_wr_ok` is `req_wr_ok` AND the change bit of the key as it stood before this update.
- R6: Access kind code 1 is a write. A write sets the change bit, key bit 1, and passes `req_wr_ok` through.
- R7: Every in-range access of any kind sets the reference bit, key bit 2. The updated key is written back and returned on `rsp_key`.
- R8: Access kind code 2 is a fetch, and the reserved code 3 behaves as a fetch. A fetch leaves the change bit as it was and passes `req_wr_ok` through.
- R9: After reset every key byte is 0, with the layout access-control bits 7:4, fetch-protect bit 3, reference bit 2 and change bit 1. Bits 7:3 and bit 0 are never altered by an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W (20) | Absolute byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as fetch |
| req_wr_ok | input | 1 | Write permission from translation |
| mem_limit | input | ADDR_W (20) | Memory size in bytes; addresses at or above it are skipped |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_wr_ok | output | 1 | Adjusted write permission |
| rsp_skip | output | 1 | Address was out of range |
| rsp_key | output | 8 | Key byte after the update (0 when skipped) |

## Verification
Assertions check the following on every cycle: the two-cycle busy window after acceptance, the single-cycle response strobe at a fixed distance from acceptance, the reference bit on every in-range result, the change bit after a write, an unchanged change bit after a fetch, the read permission rule against the key that was read, and the zero key on skipped results. Only the bench's scenarios can show which page a given address indexes and that two offsets on one page share a key. The same holds for showing that a skipped write really left its page's key untouched, which the bench checks by raising the limit and reading that page afterwards. The scenarios also cover the exact boundary at the limit and the sequence in which read permission is granted only once a write has marked the page changed.

// File: rtl/pgkey_pkg.sv
// Shared types and key-byte layout for the page storage-key updater.
// Assumes an 8-bit key byte; only the reference and change bits are written.
package pgkey_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_t;

    localparam int KEY_W   = 8;
    localparam int BIT_REF = 2;
    localparam int BIT_CHG = 1;

endpackage

// File: rtl/pgkey_ctrl.sv
// Request sequencer: accepts one request when idle, captures it, and steps
// through a look-up cycle and a commit cycle. Assumes the limit input is
// sampled at acceptance only.
module pgkey_ctrl
    import pgkey_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [1:0]                   req_kind,
    input  logic                         req_wr_ok,
    input  logic [ADDR_W-1:0]            mem_limit,
    output logic                         look_en,
    output logic                         commit_en,
    output logic [ADDR_W-PAGE_SHIFT-1:0] cur_idx,
    output acc_kind_t                    cur_kind,
    output logic                         cur_wr_ok,
    output logic                         cur_skip
);
    localparam int IDX_W = ADDR_W - PAGE_SHIFT;

    seq_state_t state_q;
    logic       accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign look_en   = (state_q == ST_LOOK);
    assign commit_en = (state_q == ST_COMMIT);

    // Advance the three-state sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (accept) state_q <= ST_LOOK;
                ST_LOOK:   state_q <= ST_COMMIT;
                ST_COMMIT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_kind  <= ACC_READ;
            cur_wr_ok <= 1'b0;
            cur_skip  <= 1'b0;
        end else if (accept) begin
            cur_idx   <= req_addr[ADDR_W-1:PAGE_SHIFT];
            cur_kind  <= acc_kind_t'(req_kind);
            cur_wr_ok <= req_wr_ok;
            cur_skip  <= (req_addr >= mem_limit);
        end
    end

    p_busy_two_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready ##1 !req_ready);

    p_ready_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> req_ready);

    logic [IDX_W-1:0] unused_idx_w;
    assign unused_idx_w = cur_idx;
endmodule

// File: rtl/pgkey_store.sv
// Key memory: one byte per page, cleared by reset, with a registered read
// port and a write port. Assumes read and write never target one entry in
// the same cycle (the sequencer separates them).
module pgkey_store
    import pgkey_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key
);
    localparam int PAGES = 1 << IDX_W;

    logic [KEY_W-1:0] keys_q [PAGES];

    // Clear on reset, otherwise store committed keys.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) keys_q[i] <= '0;
        end else if (wr_en) begin
            keys_q[wr_idx] <= wr_key;
        end
    end

    // Register the addressed key for the commit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_key <= '0;
        else if (rd_en) rd_key <= keys_q[rd_idx];
    end

    p_no_rw_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
endmodule

// File: rtl/pgkey_update.sv
// Combinational key rule: sets reference on every access, change on writes,
// and withdraws write permission on reads of an unchanged page. Assumes the
// reserved access code is handled as a fetch.
module pgkey_update
    import pgkey_pkg::*;
(
    input  logic [KEY_W-1:0] old_key,
    input  acc_kind_t        kind,
    input  logic             wr_ok_in,
    output logic [KEY_W-1:0] new_key,
    output logic             wr_ok_out
);
    // Derive the new key byte and the adjusted permission.
    always_comb begin
        new_key          = old_key;
        new_key[BIT_REF] = 1'b1;
        wr_ok_out        = wr_ok_in;
        unique case (kind)
            ACC_READ:  wr_ok_out = wr_ok_in && old_key[BIT_CHG];
            ACC_WRITE: new_key[BIT_CHG] = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/pgkey_track.sv
// Top of the page storage-key updater: sequencer, key memory and key rule,
// with registered response outputs. Assumes one request in flight at a time.
module pgkey_track
    import pgkey_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_wr_ok,
    input  logic [ADDR_W-1:0] mem_limit,
    output logic              rsp_valid,
    output logic              rsp_wr_ok,
    output logic              rsp_skip,
    output logic [7:0]        rsp_key
);
    localparam int IDX_W = ADDR_W - PAGE_SHIFT;

    logic             look_en, commit_en, cur_wr_ok, cur_skip, upd_wr_ok;
    logic [IDX_W-1:0] cur_idx;
    acc_kind_t        cur_kind;
    logic [KEY_W-1:0] rd_key, new_key;

    pgkey_ctrl #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_wr_ok(req_wr_ok),
        .mem_limit(mem_limit), .look_en(look_en), .commit_en(commit_en),
        .cur_idx(cur_idx), .cur_kind(cur_kind), .cur_wr_ok(cur_wr_ok),
        .cur_skip(cur_skip)
    );

    pgkey_store #(.IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_en(look_en && !cur_skip), .rd_idx(cur_idx), .rd_key(rd_key),
        .wr_en(commit_en && !cur_skip), .wr_idx(cur_idx), .wr_key(new_key)
    );

    pgkey_update upd_i (
        .old_key(rd_key), .kind(cur_kind), .wr_ok_in(cur_wr_ok),
        .new_key(new_key), .wr_ok_out(upd_wr_ok)
    );

    // Register the result in the commit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_wr_ok <= 1'b0;
            rsp_skip  <= 1'b0;
            rsp_key   <= '0;
        end else begin
            rsp_valid <= commit_en;
            if (commit_en) begin
                rsp_skip  <= cur_skip;
                rsp_key   <= cur_skip ? '0 : new_key;
                rsp_wr_ok <= cur_skip ? cur_wr_ok : upd_wr_ok;
            end
        end
    end

    p_rsp_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##3 rsp_valid);

    p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_skip_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_skip) |-> (rsp_key == 8'h00));

    p_read_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !cur_skip && cur_kind == ACC_READ) |=>
        (rsp_wr_ok == ($past(cur_wr_ok) && $past(rd_key[BIT_CHG]))));

    p_write_chg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !cur_skip && cur_kind == ACC_WRITE) |=> rsp_key[BIT_CHG]);

    p_ref_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_skip) |-> rsp_key[BIT_REF]);

    p_fetch_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !cur_skip && (cur_kind == ACC_FETCH || cur_kind == ACC_RSVD))
        |=> (rsp_key[BIT_CHG] == $past(rd_key[BIT_CHG])));

    p_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_key[7:3] == 5'd0 && rsp_key[0] == 1'b0));
endmodule

// File: tb/pgkey_track_tb_top.sv
// Scoreboard bench: the driver predicts each result from a bench-side key
// model and queues it; the monitor compares results as they appear.
module pgkey_track_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_wr_ok = 1'b0;
    logic [19:0] mem_limit = 20'h80000;
    logic        rsp_valid, rsp_wr_ok, rsp_skip;
    logic [7:0]  rsp_key;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic       wr_ok;
        logic       skip;
        logic [7:0] key;
    } exp_t;

    exp_t       exp_q[$];
    string      tag_q[$];
    logic [7:0] model [256];

    always #5 clk = ~clk;

    pgkey_track dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_wr_ok(req_wr_ok),
        .mem_limit(mem_limit), .rsp_valid(rsp_valid), .rsp_wr_ok(rsp_wr_ok),
        .rsp_skip(rsp_skip), .rsp_key(rsp_key)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [19:0] a, input logic [1:0] k,
                        input logic w, input string tag);
        exp_t e;
        logic [7:0] idx;
        while (!req_ready) @(negedge clk);
        idx = a[19:12];
        if (a >= mem_limit) begin
            e = '{wr_ok: w, skip: 1'b1, key: 8'h00};
        end else begin
            e.skip = 1'b0;
            e.key  = model[idx] | 8'h04;
            e.wr_ok = w;
            if (k == 2'd0) e.wr_ok = w && model[idx][1];
            if (k == 2'd1) e.key = e.key | 8'h02;
            model[idx] = e.key;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_addr = a; req_kind = k; req_wr_ok = w;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1 busy cycle 1", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b0, "R1 busy cycle 2", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready again", req_ready, 1);
    endtask

    // Monitor: compare each result with the oldest prediction.
    logic prev_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && prev_rsp)
                check(1'b0, "R2 strobe longer than one cycle", 1, 0);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected response", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rsp_key == e.key, {t, " key"}, rsp_key, e.key);
                    check(rsp_wr_ok == e.wr_ok, {t, " wr_ok"}, rsp_wr_ok, e.wr_ok);
                    check(rsp_skip == e.skip, {t, " skip"}, rsp_skip, e.skip);
                end
            end
            prev_rsp <= rsp_valid;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R9 no response after reset", rsp_valid, 0);
        // R5 R7 R9: first read of clean page loses write permission
        send(20'h05010, 2'd0, 1'b1, "R5 read clean page");
        // R3 R8: fetch at another offset of the same page
        send(20'h05FF8, 2'd2, 1'b1, "R8 fetch same page");
        // R6 R3: write sets change bit
        send(20'h05ABC, 2'd1, 1'b1, "R6 write sets change");
        send(20'h05000, 2'd0, 1'b1, "R5 read changed page");
        send(20'h05004, 2'd0, 1'b0, "R5 read without permission");
        send(20'h05100, 2'd2, 1'b0, "R8 fetch keeps change");
        send(20'h06000, 2'd3, 1'b1, "R8 reserved code as fetch");
        send(20'h06004, 2'd0, 1'b1, "R8 reserved left change clear");
        // R4: out of range write, exact limit, one below the limit
        send(20'h90123, 2'd1, 1'b0, "R4 beyond limit");
        send(20'h80000, 2'd1, 1'b1, "R4 at limit");
        send(20'h7FFFF, 2'd1, 1'b1, "R7 one below limit");
        mem_limit = 20'hFFFFF;
        send(20'h90000, 2'd0, 1'b1, "R4 skipped page untouched");
        send(20'h80008, 2'd0, 1'b1, "R4 at-limit page untouched");
        send(20'h7F000, 2'd0, 1'b1, "R3 page of last in-range write");
        send(20'h01000, 2'd1, 1'b1, "R7 write fresh page");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule